// File: doc/BRIEF.md
# Processor Bus Cycle Sequencer

This block is the bus-side state machine of a 16-bit processor whose address and data share one set of wires. The core hands it one access at a time: an address, a read/write flag, a memory/I/O flag and, for writes, the data. The sequencer then steps through the clock periods of a bus cycle, called T-states. It puts the address on the shared bus with an address-latch strobe. It then raises the read or write command together with the data-buffer enable. It stretches the cycle while the external READY input is low and collects read data. At the end it reports completion to the core.

When no access is pending, the sequencer sits in idle states one clock long and leaves the bus alone. The core may offer a new access only while `reqReady` is high, which is during an idle state or the last T-state of a cycle. An access accepted in the last T-state begins its address phase on the very next clock. All strobes are active high. The shared bus is modelled as separate `busOut`/`busIn` lines plus an output enable `busOe`. A pad ring outside the block makes the tri-state pin from them.

Top module: `busCycleSeq`

## Requirements
- R1: While `rstN` is low and in the first cycle after it, the block is idle: `ale`, `rdStb`, `wrStb`, `denStb`, `busOe`, `donePulse`, `dtR` and `mIo` are 0 and `reqReady` is 1.
- R2: A request is accepted on a rising edge where `reqValid` and `reqReady` are both 1. The next clock is T1 of its cycle. This holds whether the accepting clock was an idle state or T4.
- R3: In T1, `ale` is 1 for exactly that clock and `busOe` is 1 with `busOut` equal to the address. `dtR` is 1 for a write and 0 for a read. `mIo` is 1 for a memory access (`reqIo`=0) and 0 for an I/O access (`reqIo`=1).
- R4: In T2, `denStb` is 1 together with `rdStb` (read) or `wrStb` (write), never both. For a write, `busOe` is 1 and `busOut` carries the write data. No command strobe is active in T1.
- R5: `ready` is sampled at the end of T2 and at the end of every wait state. While it is sampled low, wait states follow, and each holds the T2 strobes and bus drive unchanged. The cycle with N wait states lasts 4+N clocks from T1 to T4 inclusive.
- R6: For a read, `busIn` is captured at the end of T3. It appears on `rdData` during T4 and stays there until the next read capture.
- R7: In T4, `rdStb`, `wrStb`, `denStb`, `ale` and `busOe` are 0 and `donePulse` is 1 for that single clock. The falling `wrStb` at the start of T4 is the write's completing edge.
- R8: With no request pending after T4, the block enters idle states of one clock each. In them `busOe`, all strobes and `donePulse` are 0, and `dtR` and `mIo` are 0.
- R9: `reqValid` while `reqReady` is 0 (T1, T2, wait states, T3) is ignored: no further cycle follows the current one.
- R10: `busOe` is 1 only in T1 and in the write-data phase (T2, wait states, T3 of a write). A read never drives the bus after T1.
- R11: `dtR` and `mIo` stay constant from T1 through T4 of a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one T-state |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Core offers an access this clock |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqIo | input | 1 | 1 = I/O space, 0 = memory space |
| reqAddr | input | BUS_W | Access address |
| reqWdata | input | BUS_W | Write data |
| reqReady | output | 1 | A request may be accepted this clock (idle or T4) |
| ready | input | 1 | External ready; low inserts wait states |
| busIn | input | BUS_W | Value seen on the shared bus |
| busOut | output | BUS_W | Value driven onto the shared bus |
| busOe | output | 1 | Shared bus output enable |
| ale | output | 1 | Address latch strobe (T1) |
| dtR | output | 1 | Transceiver direction: 1 transmit (write), 0 receive |
| mIo | output | 1 | 1 memory access, 0 I/O access |
| rdStb | output | 1 | Read command |
| wrStb | output | 1 | Write command |
| denStb | output | 1 | Data buffer enable |
| rdData | output | BUS_W | Captured read data |
| donePulse | output | 1 | One-clock completion pulse in T4 |

## Verification
Every output is a decode of the registered T-state, so each result is due in the clock right after the edge that causes it. T1 follows the accepting edge by one clock, and T2 follows T1 by one. Wait states follow each edge with `ready` low, and T4 comes one clock after T3, with `rdData` loaded at the edge that ends T3. The bench drives inputs and samples outputs on falling edges and advances exactly one falling edge per T-state. It therefore checks T1 at the first falling edge after acceptance and T4 at falling edge 4+N, and it sets `ready` and `busIn` half a clock before the edge that samples them. Every combination of direction, address space and zero to three wait states is swept, along with chained cycles and requests offered while busy.

// File: rtl/busSeqPkg.sv
package busSeqPkg;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_TW   = 3'd3,
    TS_T3   = 3'd4,
    TS_T4   = 3'd5
  } tState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic driveAddr;
    logic driveData;
    logic captureRd;
  } dpStrobe_t;

endpackage

// File: rtl/busSeqCtrl.sv
module busSeqCtrl
  import busSeqPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      ready,
  input  logic      heldWrite,
  input  logic      heldIo,
  output dpStrobe_t strb,
  output logic      reqReady,
  output logic      ale,
  output logic      dtR,
  output logic      mIo,
  output logic      rdStb,
  output logic      wrStb,
  output logic      denStb,
  output logic      donePulse
);

  tState_e state, stateNext;
  logic    accept, inCmd, active;

  assign reqReady = (state == TS_IDLE) || (state == TS_T4);
  assign accept   = reqValid && reqReady;
  assign inCmd    = (state == TS_T2) || (state == TS_TW) || (state == TS_T3);
  assign active   = (state != TS_IDLE);

  always_comb begin
    stateNext = state;
    unique case (state)
      TS_IDLE: stateNext = accept ? TS_T1 : TS_IDLE;
      TS_T1:   stateNext = TS_T2;
      TS_T2:   stateNext = ready ? TS_T3 : TS_TW;
      TS_TW:   stateNext = ready ? TS_T3 : TS_TW;
      TS_T3:   stateNext = TS_T4;
      TS_T4:   stateNext = accept ? TS_T1 : TS_IDLE;
      default: stateNext = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= TS_IDLE;
    else       state <= stateNext;
  end

  assign ale       = (state == TS_T1);
  assign dtR       = active && heldWrite;
  assign mIo       = active && !heldIo;
  assign rdStb     = inCmd && !heldWrite;
  assign wrStb     = inCmd && heldWrite;
  assign denStb    = inCmd;
  assign donePulse = (state == TS_T4);

  assign strb.loadReq   = accept;
  assign strb.driveAddr = (state == TS_T1);
  assign strb.driveData = inCmd && heldWrite;
  assign strb.captureRd = (state == TS_T3) && !heldWrite;

  assert_start_after_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> ale);

  assert_ale_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale);

  assert_cmd_after_ale_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(denStb) |-> $past(ale));

  assert_wait_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (((state == TS_T2) || (state == TS_TW)) && !ready)
      |=> (state == TS_TW) && $stable(rdStb) && $stable(wrStb));

  assert_done_on_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(denStb) |-> donePulse);

  assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> !ale);

  assert_held_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    (inCmd || donePulse) |-> ($stable(dtR) && $stable(mIo)));

endmodule

// File: rtl/busSeqDatapath.sv
module busSeqDatapath
  import busSeqPkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic             reqWrite,
  input  logic             reqIo,
  input  logic [BUS_W-1:0] reqAddr,
  input  logic [BUS_W-1:0] reqWdata,
  input  logic [BUS_W-1:0] busIn,
  output logic             heldWrite,
  output logic             heldIo,
  output logic [BUS_W-1:0] busOut,
  output logic             busOe,
  output logic [BUS_W-1:0] rdData
);

  logic [BUS_W-1:0] heldAddr, heldData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldWrite <= 1'b0;
      heldIo    <= 1'b0;
      heldAddr  <= '0;
      heldData  <= '0;
    end else if (strb.loadReq) begin
      heldWrite <= reqWrite;
      heldIo    <= reqIo;
      heldAddr  <= reqAddr;
      heldData  <= reqWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               rdData <= '0;
    else if (strb.captureRd) rdData <= busIn;
  end

  assign busOe  = strb.driveAddr || strb.driveData;
  assign busOut = strb.driveAddr ? heldAddr :
                  strb.driveData ? heldData : '0;

  assert_capture_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.captureRd |=> (rdData == $past(busIn)));

endmodule

// File: rtl/busCycleSeq.sv
module busCycleSeq
  import busSeqPkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic             reqIo,
  input  logic [BUS_W-1:0] reqAddr,
  input  logic [BUS_W-1:0] reqWdata,
  output logic             reqReady,
  input  logic             ready,
  input  logic [BUS_W-1:0] busIn,
  output logic [BUS_W-1:0] busOut,
  output logic             busOe,
  output logic             ale,
  output logic             dtR,
  output logic             mIo,
  output logic             rdStb,
  output logic             wrStb,
  output logic             denStb,
  output logic [BUS_W-1:0] rdData,
  output logic             donePulse
);

  dpStrobe_t strb;
  logic      heldWrite, heldIo;

  busSeqCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .ready     (ready),
    .heldWrite (heldWrite),
    .heldIo    (heldIo),
    .strb      (strb),
    .reqReady  (reqReady),
    .ale       (ale),
    .dtR       (dtR),
    .mIo       (mIo),
    .rdStb     (rdStb),
    .wrStb     (wrStb),
    .denStb    (denStb),
    .donePulse (donePulse)
  );

  busSeqDatapath #(.BUS_W(BUS_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqWrite  (reqWrite),
    .reqIo     (reqIo),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .busIn     (busIn),
    .heldWrite (heldWrite),
    .heldIo    (heldIo),
    .busOut    (busOut),
    .busOe     (busOe),
    .rdData    (rdData)
  );

  assert_tristate_R10: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> (ale || wrStb));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!ale && !denStb && !donePulse) |-> (!busOe && !dtR && !mIo));

endmodule

// File: tb/sim_busCycleSeq.sv
`timescale 1ns/1ps
module sim_busCycleSeq;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0, reqWrite = 1'b0, reqIo = 1'b0;
  logic [W-1:0] reqAddr = '0, reqWdata = '0;
  logic         reqReady;
  logic         ready = 1'b1;
  logic [W-1:0] busIn = '0;
  logic [W-1:0] busOut, rdData;
  logic         busOe, ale, dtR, mIo, rdStb, wrStb, denStb, donePulse;

  int nChk = 0;
  int nBad = 0;

  always #2 clk = ~clk;

  busCycleSeq #(.BUS_W(W)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqIo(reqIo), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .ready(ready), .busIn(busIn), .busOut(busOut), .busOe(busOe), .ale(ale),
    .dtR(dtR), .mIo(mIo), .rdStb(rdStb), .wrStb(wrStb), .denStb(denStb),
    .rdData(rdData), .donePulse(donePulse)
  );

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkIdle(input string tag);
    chkEq({tag, " R8 strobes"}, {ale, rdStb, wrStb, denStb, donePulse}, 0);
    chkEq({tag, " R8 busOe"}, busOe, 0);
    chkEq({tag, " R8 dtR/mIo"}, {dtR, mIo}, 0);
    chkEq({tag, " R8 reqReady"}, reqReady, 1);
  endtask

  task automatic startReq(input logic w, input logic io, input logic [W-1:0] a,
                          input logic [W-1:0] d);
    chkEq("R2 reqReady before offer", reqReady, 1);
    reqValid = 1'b1; reqWrite = w; reqIo = io; reqAddr = a; reqWdata = d;
  endtask

  // called at the falling edge where the request is offered; returns at T4's falling edge
  task automatic runCycle(input logic w, input logic io, input logic [W-1:0] a,
                          input logic [W-1:0] d, input int nWait,
                          input logic [W-1:0] rv, input bit injectIgnored);
    @(negedge clk); // T1
    reqValid = 1'b0;
    chkEq("R2 ale in T1", ale, 1);
    chkEq("R3 busOe T1", busOe, 1);
    chkEq("R3 address on bus", busOut, a);
    chkEq("R3 dtR", dtR, w);
    chkEq("R3 mIo", mIo, !io);
    chkEq("R4 no command in T1", {rdStb, wrStb, denStb, donePulse}, 0);
    chkEq("R9 busy in T1", reqReady, 0);
    @(negedge clk); // T2
    ready = (nWait == 0);
    if (injectIgnored) begin
      reqValid = 1'b1; reqWrite = !w; reqAddr = ~a;
    end
    chkEq("R3 ale one clock", ale, 0);
    chkEq("R4 T2 strobes", {rdStb, wrStb, denStb}, {!w, w, 1'b1});
    chkEq("R10 busOe T2", busOe, w);
    if (w) chkEq("R4 write data", busOut, d);
    chkEq("R11 dtR/mIo T2", {dtR, mIo}, {w, !io});
    for (int k = 1; k <= nWait; k++) begin
      @(negedge clk); // wait state
      reqValid = 1'b0;
      ready = (k == nWait);
      chkEq("R5 wait strobes held", {rdStb, wrStb, denStb}, {!w, w, 1'b1});
      chkEq("R5 no done in wait", donePulse, 0);
      chkEq("R10 busOe wait", busOe, w);
      if (w) chkEq("R5 write data held", busOut, d);
    end
    @(negedge clk); // T3
    reqValid = 1'b0;
    ready = 1'b0;
    busIn = rv;
    chkEq("R5 T3 strobes", {rdStb, wrStb, denStb, donePulse}, {!w, w, 1'b1, 1'b0});
    chkEq("R10 busOe T3", busOe, w);
    chkEq("R11 dtR/mIo T3", {dtR, mIo}, {w, !io});
    @(negedge clk); // T4 at clock 4+nWait
    busIn = ~rv;
    ready = 1'b1;
    chkEq("R7 done in T4", donePulse, 1);
    chkEq("R7 released in T4", {ale, rdStb, wrStb, denStb, busOe}, 0);
    chkEq("R11 dtR/mIo T4", {dtR, mIo}, {w, !io});
    chkEq("R2 reqReady T4", reqReady, 1);
    if (!w) chkEq("R6 read data", rdData, rv);
  endtask

  initial begin
    bit finished;
    finished = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chkEq("R1 reset strobes", {ale, rdStb, wrStb, denStb, donePulse, busOe, dtR, mIo}, 0);
    chkEq("R1 reset reqReady", reqReady, 1);
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R1 after reset");

    for (int w = 0; w < 2; w++)
      for (int io = 0; io < 2; io++)
        for (int n = 0; n < 4; n++) begin
          int idx;
          logic [W-1:0] a;
          idx = w * 8 + io * 4 + n;
          a = W'(16'h1000 + idx * 37);
          startReq(w[0], io[0], a, ~a);
          runCycle(w[0], io[0], a, ~a, n, a ^ 16'h5A5A, (idx % 3) == 0);
          reqValid = 1'b0;
          @(negedge clk);
          checkIdle("R9 no cycle after busy offer");
          @(negedge clk);
          checkIdle("idle repeats");
        end

    // chained cycles: offers in T4 start T1 on the next clock
    startReq(1'b1, 1'b0, 16'hA001, 16'hBEEF);
    runCycle(1'b1, 1'b0, 16'hA001, 16'hBEEF, 1, 16'h0, 1'b0);
    startReq(1'b0, 1'b1, 16'h00F3, 16'h0);
    runCycle(1'b0, 1'b1, 16'h00F3, 16'h0, 0, 16'h1234, 1'b0);
    startReq(1'b0, 1'b0, 16'hFFFE, 16'h0);
    runCycle(1'b0, 1'b0, 16'hFFFE, 16'h0, 2, 16'hC3C3, 1'b0);
    reqValid = 1'b0;
    @(negedge clk);
    checkIdle("chain end");
    chkEq("R6 read data held", rdData, 16'hC3C3);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule